// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets boot firmware read configuration items through two registers. Firmware writes a 16-bit key to the selector register. The key picks one item from an internal store and sets the byte cursor back to zero. Each read of the data register then returns the next bytes of that item. The bytes are packed with the first byte in the most significant position, and the cursor moves forward by the number of bytes delivered. Once the item runs out, the missing bytes read as zero.

The store has two banks of the same size. Key bit 15 chooses the bank and key bits 14:0 index into it. An index at or above the entry count (the first file key plus the number of file slots) gives an invalid selection. The store contents are fixed at build time from a computed table, so the byte stream of every item is known in advance. A parameter chooses the combined variant, which uses one register for everything: the address is ignored, a 1-byte read is a data read and a 2-byte write is a select.

Top module: `cfg_item_port`

## Requirements
- R1: A 2-byte write to the selector (bus_addr=1) loads the key and always sets the byte cursor to zero, even if the same key was already selected.
- R2: Key bit 15 picks bank 1 when set and bank 0 when clear. Key bits 14:0 give the entry index within that bank.
- R3: An index at or above ENTRIES = FIRST_FILE_KEY + FILE_SLOTS (8 by default) makes the selection invalid. Every data read of an invalid selection returns zero.
- R4: A data read of N bytes (bus_size=N, with N from 1 to 8) puts the byte at the cursor in bits 8N-1:8N-8, the next byte below it, and so on. All bits above 8N are zero. The cursor advances by the number of bytes delivered.
- R5: When the item ends partway through an access, the bytes that were delivered keep their upper positions and the missing low bytes read as zero.
- R6: A read with the cursor at or past the item length, or of an entry of length 0, returns zero and leaves the cursor unchanged.
- R7: After reset the selected key is 0, bank 0, which holds the signature. A 4-byte read then returns 0x4346474B.
- R8: The selector accepts only 2-byte writes. Writes of any other size leave the selection and cursor unchanged. A read at the selector address returns zero and does not move the cursor.
- R9: Writes to the data register (bus_addr=0) are ignored and leave the cursor unchanged.
- R10: With COMBINED=1 the address is ignored. A 1-byte read is a data read, a 2-byte write is a select, and reads of any other size return zero without moving the cursor.
- R11: Entry 0 of bank 0 holds the 4 signature bytes, most significant first. Every other entry (bank b, index i) has length (5i+3b) mod 13 and byte k = {b, i[2:0], k[3:0]} XOR 0xA5.
- R12: Every read request raises bus_rvalid for exactly the next cycle, with bus_rdata valid in that cycle. Write cycles do not raise it. A data read of size 0 or above 8 returns zero and leaves the cursor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 1 = selector register, 0 = data register (ignored when COMBINED=1) |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 16 | Write data; the key for a select |
| bus_rdata | output | 8*LANES (64) | Read result, right-aligned, registered |
| bus_rvalid | output | 1 | Read result valid, one cycle after the request |

## Verification
The selector and the data path collide when a select is immediately followed, in the next cycle, by a data read. In that case the new key and the cleared cursor must already be in effect for the read. A dedicated back-to-back task provokes this, and the result is judged against the first bytes of the newly selected item. A second collision happens inside a single beat when an 8-byte read crosses the end of an item: packing, zero padding and the shortened cursor advance all occur together. The task judges the padded value and then confirms the cursor stopped at the item length, using a following read that must return zero.

// File: rtl/cfgip_pkg.sv
// Package: shared constants and the build-time item table formulas.
// Assumes: keys are 16 bits with the bank flag in the top bit.
package cfgip_pkg;

    localparam int KEY_W    = 16;
    localparam int BANK_BIT = KEY_W - 1;
    localparam int SEL_SIZE = 2;

    // Length of item (bank, idx); entry 0 of bank 0 is the 4-byte signature.
    function automatic int item_len(input int bank, input int idx, input int max_len);
        int l;
        if (bank == 0 && idx == 0) begin
            l = 4;
        end else begin
            l = (idx * 5 + bank * 3) % 13;
        end
        return (l > max_len) ? max_len : l;
    endfunction

    // Byte at offset off of item (bank, idx).
    function automatic logic [7:0] item_byte(input int bank, input int idx,
                                             input int off, input logic [31:0] sig);
        logic [7:0] b;
        if (bank == 0 && idx == 0) begin
            b = (off < 4) ? 8'(sig >> (8 * (3 - off))) : 8'h00;
        end else begin
            b = {bank[0], idx[2:0], off[3:0]} ^ 8'hA5;
        end
        return b;
    endfunction

endpackage

// File: rtl/cfgip_bus_decode.sv
// Module: cfgip_bus_decode
// Turns one bus request into a select strobe, a data-read strobe and a
// read-response strobe. COMBINED picks the single-register decoding.
// Assumes: at most one request per cycle.
module cfgip_bus_decode #(
    parameter int COMBINED = 0
) (
    input  logic       req,
    input  logic       wr,
    input  logic       addr,
    input  logic [3:0] size,
    output logic       sel_fire,
    output logic       rd_fire,
    output logic       rd_any
);
    import cfgip_pkg::*;

    // Any read request gets a response beat.
    assign rd_any = req && !wr;

    generate
        if (COMBINED != 0) begin : g_comb
            logic unused_addr;
            assign unused_addr = addr;
            // Single register: size alone separates select from data.
            assign sel_fire = req && wr && (size == 4'(SEL_SIZE));
            assign rd_fire  = req && !wr && (size == 4'd1);
        end else begin : g_split
            // Separate registers: address picks selector or data.
            assign sel_fire = req && wr && addr && (size == 4'(SEL_SIZE));
            assign rd_fire  = req && !wr && !addr;
        end
    endgenerate

endmodule

// File: rtl/cfgip_item_store.sv
// Module: cfgip_item_store
// Constant two-bank item store with LANES byte read ports starting at the
// current cursor, plus the length of the selected item.
// Assumes: idx is only meaningful while sel_valid is high.
module cfgip_item_store #(
    parameter int          ENTRIES   = 8,
    parameter int          MAX_LEN   = 16,
    parameter int          LANES     = 8,
    parameter logic [31:0] SIGNATURE = 32'h4346474B,
    localparam int         IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int         OFF_W     = $clog2(MAX_LEN + 1)
) (
    input  logic             sel_valid,
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] off,
    output logic [OFF_W-1:0] len,
    output logic [7:0]       lane [LANES]
);
    import cfgip_pkg::*;

    localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int LW = OFF_W + 4;

    logic [7:0]       rom     [2][ENTRIES][MAX_LEN];
    logic [OFF_W-1:0] len_tab [2][ENTRIES];
    logic             hit;

    // Build the constant table from the package formulas.
    generate
        for (genvar gb = 0; gb < 2; gb++) begin : g_bank
            for (genvar ge = 0; ge < ENTRIES; ge++) begin : g_ent
                assign len_tab[gb][ge] = OFF_W'(item_len(gb, ge, MAX_LEN));
                for (genvar go = 0; go < MAX_LEN; go++) begin : g_byte
                    assign rom[gb][ge][go] = item_byte(gb, ge, go, SIGNATURE);
                end
            end
        end
    endgenerate

    // A valid selection always points inside the table.
    assign hit = sel_valid && (int'(idx) < ENTRIES);

    // Length of the current item; an invalid selection has none.
    assign len = hit ? len_tab[bank][idx] : '0;

    // One read port per lane at cursor + lane number.
    generate
        for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
            logic [LW-1:0] a;
            assign a = LW'(off) + LW'(gl);
            always_comb begin
                lane[gl] = (hit && (a < LW'(MAX_LEN))) ? rom[bank][idx][a[AW-1:0]] : 8'h00;
            end
        end
    endgenerate

endmodule

// File: rtl/cfgip_read_engine.sv
// Module: cfgip_read_engine
// Packs up to LANES bytes most-significant first into a right-aligned
// word of the requested size and reports how many bytes were delivered.
// Assumes: lane[k] is the byte at cursor + k.
module cfgip_read_engine #(
    parameter int  LANES  = 8,
    parameter int  OFF_W  = 5,
    localparam int DATA_W = 8 * LANES
) (
    input  logic              sel_valid,
    input  logic [OFF_W-1:0]  len,
    input  logic [OFF_W-1:0]  off,
    input  logic [3:0]        size,
    input  logic [7:0]        lane [LANES],
    output logic [DATA_W-1:0] value,
    output logic [3:0]        take
);
    localparam int EW = (OFF_W > 4) ? OFF_W : 4;

    logic [OFF_W-1:0] avail;
    logic             size_ok;

    // Bytes left in the item from the cursor.
    always_comb begin
        avail = (off < len) ? (len - off) : '0;
    end

    // Delivered byte count: the smaller of the size and the bytes left.
    always_comb begin
        size_ok = (size != 4'd0) && (size <= 4'(LANES));
        if (!sel_valid || !size_ok) begin
            take = 4'd0;
        end else if (EW'(avail) < EW'(size)) begin
            take = 4'(avail);
        end else begin
            take = size;
        end
    end

    // Place delivered bytes from the top of the access downward.
    always_comb begin
        value = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(take)) begin
                value = value | (DATA_W'(lane[k]) << (8 * (int'(size) - 1 - k)));
            end
        end
    end

endmodule

// File: rtl/cfg_item_port.sv
// Module: cfg_item_port (top)
// Register port for reading keyed configuration items: a selector register
// and a data register (or one combined register when COMBINED=1).
// Assumes: synchronous active-low reset; one request per cycle; read data
// returns one cycle after the request.
module cfg_item_port #(
    parameter int          FIRST_FILE_KEY = 4,
    parameter int          FILE_SLOTS     = 4,
    parameter int          MAX_LEN        = 16,
    parameter int          LANES          = 8,
    parameter int          COMBINED       = 0,
    parameter logic [31:0] SIGNATURE      = 32'h4346474B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [3:0]           bus_size,
    input  logic [15:0]          bus_wdata,
    output logic [8*LANES-1:0]   bus_rdata,
    output logic                 bus_rvalid
);
    import cfgip_pkg::*;

    localparam int ENTRIES = FIRST_FILE_KEY + FILE_SLOTS;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int OFF_W   = $clog2(MAX_LEN + 1);
    localparam int DATA_W  = 8 * LANES;
    localparam int IXK_W   = KEY_W - 1;

    logic              sel_fire, rd_fire, rd_any;
    logic              bank_q, valid_q;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  cur_len;
    logic [7:0]        lane [LANES];
    logic [DATA_W-1:0] value;
    logic [3:0]        take;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    logic              key_ok;

    cfgip_bus_decode #(.COMBINED(COMBINED)) u_dec (
        .req      (bus_req),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .size     (bus_size),
        .sel_fire (sel_fire),
        .rd_fire  (rd_fire),
        .rd_any   (rd_any)
    );

    cfgip_item_store #(
        .ENTRIES   (ENTRIES),
        .MAX_LEN   (MAX_LEN),
        .LANES     (LANES),
        .SIGNATURE (SIGNATURE)
    ) u_store (
        .sel_valid (valid_q),
        .bank      (bank_q),
        .idx       (idx_q),
        .off       (off_q),
        .len       (cur_len),
        .lane      (lane)
    );

    cfgip_read_engine #(.LANES(LANES), .OFF_W(OFF_W)) u_eng (
        .sel_valid (valid_q),
        .len       (cur_len),
        .off       (off_q),
        .size      (bus_size),
        .lane      (lane),
        .value     (value),
        .take      (take)
    );

    // Masked key index must fall below the entry count.
    assign key_ok = (32'(bus_wdata[IXK_W-1:0]) < 32'(ENTRIES));

    // Selection and cursor state: select loads the key, reads advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= 1'b0;
            idx_q   <= '0;
            valid_q <= 1'b1;
            off_q   <= '0;
        end else if (sel_fire) begin
            bank_q  <= bus_wdata[BANK_BIT];
            idx_q   <= IDX_W'(bus_wdata[IXK_W-1:0]);
            valid_q <= key_ok;
            off_q   <= '0;
        end else if (rd_fire) begin
            off_q   <= off_q + OFF_W'(take);
        end
    end

    // Registered read response, one beat per read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_any;
            rdata_q  <= rd_fire ? value : '0;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    // R1: cursor is zero in the cycle after any select.
    a_r1_select_zeroes_cursor: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fire |=> (off_q == '0));

    // R3: reads of an invalid selection return zero.
    a_r3_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !valid_q) |=> (bus_rdata == '0));

    // R6: the cursor never passes the length of the selected item.
    a_r6_cursor_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= cur_len);

    // R6: a read at or past the end leaves the cursor where it was.
    a_r6_end_holds_cursor: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && (off_q >= cur_len)) |=> $stable(off_q));

    // R4: a read advances the cursor by no more than its size.
    a_r4_advance_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> ((int'(off_q) >= int'($past(off_q))) &&
                     (int'(off_q) - int'($past(off_q)) <= int'($past(bus_size)))));

    // R12: response beat follows each read request and only those.
    a_r12_rvalid_tracks_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> bus_rvalid);
    a_r12_no_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !bus_rvalid);

endmodule

// File: tb/sim_cfg_item_port.sv
// Directed bench for cfg_item_port: u0 uses split registers, u1 the combined one.
module sim_cfg_item_port;

    logic        clk;
    logic        rst_n;
    logic        req, wr, addr;
    logic [3:0]  size;
    logic [15:0] wdata;
    logic [63:0] rdata;
    logic        rvalid;
    logic        c_req, c_wr, c_addr;
    logic [3:0]  c_size;
    logic [15:0] c_wdata;
    logic [63:0] c_rdata;
    logic        c_rvalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state per instance: 0 = u0, 1 = u1.
    bit m_valid [2];
    int m_bank  [2];
    int m_idx   [2];
    int m_off   [2];

    cfg_item_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_wr(wr), .bus_addr(addr),
        .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid)
    );

    cfg_item_port #(.COMBINED(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_req(c_req), .bus_wr(c_wr), .bus_addr(c_addr),
        .bus_size(c_size), .bus_wdata(c_wdata), .bus_rdata(c_rdata), .bus_rvalid(c_rvalid)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    // Item table per R11.
    function automatic int e_len(int b, int i);
        if (b == 0 && i == 0) return 4;
        return (i * 5 + b * 3) % 13;
    endfunction

    function automatic logic [7:0] e_byte(int b, int i, int o);
        logic [31:0] sig;
        sig = 32'h4346474B;
        if (b == 0 && i == 0) return 8'(sig >> (8 * (3 - o)));
        return {b[0], i[2:0], o[3:0]} ^ 8'hA5;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus access on instance c; returns the response sampled a cycle later.
    task automatic acc(bit c, logic w, logic a, logic [3:0] s, logic [15:0] d,
                       output logic [63:0] r, output logic v);
        @(negedge clk);
        if (c) begin
            c_req = 1; c_wr = w; c_addr = a; c_size = s; c_wdata = d;
        end else begin
            req = 1; wr = w; addr = a; size = s; wdata = d;
        end
        @(negedge clk);
        c_req = 0; req = 0;
        r = c ? c_rdata : rdata;
        v = c ? c_rvalid : rvalid;
    endtask

    function automatic void model_sel(bit c, logic [15:0] key);
        m_bank[c]  = int'(key[15]);
        m_idx[c]   = int'(key[14:0]);
        m_valid[c] = (m_idx[c] < 8);
        m_off[c]   = 0;
    endfunction

    // Expected read value per R4/R5/R6/R10/R12, advancing the model cursor.
    function automatic logic [63:0] model_rd(bit c, int s);
        logic [63:0] e;
        int avail, take;
        bit ok;
        e = 0;
        take = 0;
        ok = c ? (s == 1) : (s >= 1 && s <= 8);
        if (m_valid[c] && ok) begin
            avail = e_len(m_bank[c], m_idx[c]) - m_off[c];
            if (avail < 0) avail = 0;
            take = (avail < s) ? avail : s;
            for (int k = 0; k < take; k++)
                e = e | (64'(e_byte(m_bank[c], m_idx[c], m_off[c] + k)) << (8 * (s - 1 - k)));
        end
        m_off[c] += take;
        return e;
    endfunction

    task automatic sel(bit c, logic [15:0] key, string tag);
        logic [63:0] r;
        logic v;
        acc(c, 1'b1, 1'b1, 4'd2, key, r, v);
        model_sel(c, key);
        check({tag, " R12 no rvalid on write"}, 64'(v), 64'd0);
    endtask

    task automatic rd(bit c, int s, string tag);
        logic [63:0] r, e;
        logic v;
        acc(c, 1'b0, 1'b0, 4'(s), 16'h0, r, v);
        e = model_rd(c, s);
        check(tag, r, e);
        check({tag, " R12 rvalid"}, 64'(v), 64'd1);
    endtask

    task automatic t_reset();
        logic [63:0] r;
        logic v;
        check("R12 reset rvalid low", 64'(rvalid), 64'd0);
        check("R7 reset rdata zero", rdata, 64'd0);
        acc(0, 1'b0, 1'b0, 4'd4, 16'h0, r, v);
        check("R7 signature after reset", r, 64'h4346474B);
        m_off[0] = 4;
        rd(0, 1, "R6 read past signature end");
    endtask

    task automatic t_pad();
        logic [63:0] r;
        logic v;
        sel(0, 16'h0002, "R1");
        acc(0, 1'b0, 1'b0, 4'd8, 16'h0, r, v);
        check("R4 8-byte pack bank0 idx2", r, 64'h8584878681808382);
        m_off[0] = 8;
        acc(0, 1'b0, 1'b0, 4'd8, 16'h0, r, v);
        check("R5 tail padded", r, 64'h8d8c000000000000);
        m_off[0] = 10;
        rd(0, 4, "R6 cursor held at end");
        rd(0, 2, "R6 still zero at end");
    endtask

    task automatic t_bank1();
        sel(0, 16'h8001, "R2");
        rd(0, 3, "R2 bank1 idx1 first 3");
        rd(0, 5, "R4 bank1 idx1 next 5");
        sel(0, 16'h8002, "R6");
        rd(0, 4, "R6 empty entry zero");
        sel(0, 16'h0001, "R2");
        rd(0, 2, "R2 bank0 idx1 differs from bank1");
    endtask

    task automatic t_invalid();
        sel(0, 16'h0008, "R3");
        rd(0, 4, "R3 index at entry count invalid");
        sel(0, 16'h7FFF, "R3");
        rd(0, 1, "R3 max index invalid");
    endtask

    task automatic t_selector_rules();
        logic [63:0] r;
        logic v;
        sel(0, 16'h0002, "R1");
        rd(0, 1, "R1 fresh select first byte");
        acc(0, 1'b1, 1'b1, 4'd4, 16'h0003, r, v);
        acc(0, 1'b1, 1'b1, 4'd1, 16'h0003, r, v);
        rd(0, 1, "R8 non-2-byte select ignored");
        acc(0, 1'b0, 1'b1, 4'd2, 16'h0, r, v);
        check("R8 selector read zero", r, 64'd0);
        rd(0, 1, "R8 selector read kept cursor");
        acc(0, 1'b1, 1'b0, 4'd1, 16'hFFFF, r, v);
        acc(0, 1'b1, 1'b0, 4'd2, 16'h0005, r, v);
        rd(0, 2, "R9 data write ignored");
        sel(0, 16'h0002, "R1");
        rd(0, 2, "R1 reselect same key restarts");
    endtask

    task automatic t_bad_size();
        sel(0, 16'h0005, "R12");
        rd(0, 0, "R12 size 0 zero");
        rd(0, 9, "R12 size 9 zero");
        rd(0, 4, "R12 cursor unmoved by bad sizes");
    endtask

    // Select and read on consecutive cycles.
    task automatic t_back_to_back();
        logic [63:0] e;
        sel(0, 16'h0007, "R1");
        rd(0, 3, "R4 idx7 prefix");
        @(negedge clk);
        req = 1; wr = 1; addr = 1; size = 2; wdata = 16'h8000;
        @(negedge clk);
        req = 1; wr = 0; addr = 0; size = 4; wdata = 0;
        model_sel(0, 16'h8000);
        @(negedge clk);
        req = 0;
        e = model_rd(0, 4);
        check("R1 read right after select", rdata, e);
        check("R12 rvalid after back-to-back", 64'(rvalid), 64'd1);
    endtask

    task automatic t_combined();
        logic [63:0] r;
        logic v;
        rd(1, 1, "R10 combined signature byte");
        check("R10 combined first byte is 0x43", 64'h43, 64'(e_byte(0, 0, 0)));
        sel(1, 16'h0003, "R10");
        acc(1, 1'b0, 1'b1, 4'd4, 16'h0, r, v);
        check("R10 combined wide read zero", r, 64'd0);
        rd(1, 1, "R10 combined data read idx3");
        rd(1, 1, "R10 combined second byte");
        rd(1, 1, "R10 combined past end");
    endtask

    initial begin
        req = 0; wr = 0; addr = 0; size = 0; wdata = 0;
        c_req = 0; c_wr = 0; c_addr = 0; c_size = 0; c_wdata = 0;
        for (int c = 0; c < 2; c++) model_sel(c[0], 16'h0000);
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_pad();
        t_bank1();
        t_invalid();
        t_selector_rules();
        t_bad_size();
        t_back_to_back();
        t_combined();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule